// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads a two-level translation table that is stored in ordinary memory. A requester presents the virtual address, an access kind (read, write or execute) and the current table base register. The walker then reads the first-level (directory) word and the second-level (table) word over a single-word memory port. It checks that both entries are present and that the access kind is permitted. If the access is a store to a page that has not yet been marked modified, the walker writes the table word back with its modified flag set. Finally it returns either the physical address or a fault cause.

The walker handles one translation at a time. `busy` holds off new requests from the cycle after acceptance until the response pulse has been given. The memory port uses a hold-until-acknowledge handshake, so any latency works.

The controller has five named states:
- `S_IDLE`: waits for `req_valid`.
- `S_DIR_RD`: fetches the directory word.
- `S_TBL_RD`: fetches the table word.
- `S_DIRTY_WR`: stores the marked table word.
- `S_DONE`: presents the one-cycle response.

The transitions are:
- `S_IDLE`→`S_DIR_RD` on a request.
- `S_DIR_RD`→`S_DONE` on an absent directory entry.
- `S_DIR_RD`→`S_TBL_RD` on a present one.
- `S_TBL_RD`→`S_DONE` on an absent entry, a denied access, or a permitted access that needs no store.
- `S_TBL_RD`→`S_DIRTY_WR` on a permitted store to a clean page.
- `S_DIRTY_WR`→`S_DONE` on the write acknowledge.
- `S_DONE`→`S_IDLE` always.

Top module: `ptw_walker`

## Requirements
- R1: The walker splits the virtual address into three fields: bits 31:22 are the directory index, bits 21:12 are the table index, and bits 11:0 are the offset. The first memory access is a read of `base + 4*dir_index`, using the base register value captured when the request was accepted.
- R2: A directory word is present when bit 0 is 1, and its bits 31:12 name the page that holds the table. The second access is a read of `{dir_word[31:12], 12'h000} + 4*table_index`.
- R3: In a table word, bits 31:12 are the page number, bit 0 is present, bit 1 is read allowed, bit 2 is write allowed, bit 3 is execute allowed, and bit 4 is modified. A permitted access responds with cause 2'b00 and `rsp_paddr = {page_number, offset}`.
- R4: An absent directory or table entry responds with cause 2'b01 and `rsp_paddr = 0`. No further memory access is made after the read that found it.
- R5: Access codes are 2'b00 read, 2'b01 write, 2'b10 execute. Code 2'b11 is never permitted. A present entry without the matching allow bit responds with cause 2'b10 and `rsp_paddr = 0`, and no memory write takes place.
- R6: A permitted write whose table word has bit 4 clear makes a third access. It writes the same table address with the fetched word plus bit 4 set, and the response follows that write's acknowledge. With bit 4 already set, no write is made.
- R7: `busy` is high from the cycle after acceptance through the response cycle. `req_valid` is ignored while `busy` is high.
- R8: `rsp_valid` is a one-cycle pulse per accepted request, and `rsp_vaddr` repeats the accepted virtual address.
- R9: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay steady until the cycle in which `mem_ack` is sampled high. Any latency is accepted, including an acknowledge in the first cycle of the request.
- R10: After reset, `busy`, `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| base_reg | input | 32 | Physical address of the directory |
| busy | output | 1 | Walk in progress; requests ignored |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_cause | output | 2 | 00 ok, 01 not present, 10 protection |
| rsp_vaddr | output | 32 | Virtual address of the finished walk |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The permission check and the modified-flag store are decided on the same table word in the same acknowledge cycle, so they can collide. A store to a clean page that lacks write permission must raise the protection cause and must not issue the write. The bench provokes this with a read-only, clean table word and a write request. It judges the outcome by the response cause and by the access log of its memory model, which must show exactly two reads and no write, with the stored word left unchanged. A second overlap is a request held high across the response cycle. Only one response with the original address may appear.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_OK   = 2'b00,
        CAUSE_NP   = 2'b01,
        CAUSE_PROT = 2'b10
    } cause_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_TBL_RD,
        S_DIRTY_WR,
        S_DONE
    } walk_state_e;

    // flag positions inside an entry word
    localparam int unsigned FLAG_W   = 5;
    localparam int unsigned F_VALID  = 0;
    localparam int unsigned F_RD     = 1;
    localparam int unsigned F_WR     = 2;
    localparam int unsigned F_EX     = 3;
    localparam int unsigned F_DIRTY  = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned AW       = 32,
    parameter int unsigned DIR_BITS = 10,
    parameter int unsigned TBL_BITS = 10,
    parameter int unsigned OFF_BITS = 12
) (
    input  logic [AW-1:0]          vaddr,
    input  logic [AW-1:0]          base,
    input  logic [AW-OFF_BITS-1:0] tbl_ppn,
    input  logic [AW-OFF_BITS-1:0] page_ppn,
    output logic [AW-1:0]          dir_ent_addr,
    output logic [AW-1:0]          tbl_ent_addr,
    output logic [AW-1:0]          paddr
);

    localparam int unsigned DIR_OFS_W = DIR_BITS + 2;
    localparam int unsigned TBL_OFS_W = TBL_BITS + 2;

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] tbl_idx;
    logic [OFF_BITS-1:0] pg_off;

    initial begin
        split_fits_chk: assert (DIR_BITS + TBL_BITS + OFF_BITS == AW)
            else $error("address fields do not cover the address");
    end

    always_comb begin
        dir_idx = vaddr[AW-1 -: DIR_BITS];
        tbl_idx = vaddr[OFF_BITS +: TBL_BITS];
        pg_off  = vaddr[OFF_BITS-1:0];
    end

    // entries are four bytes wide, hence the two zero bits
    always_comb begin
        dir_ent_addr = base + AW'(DIR_OFS_W'({dir_idx, 2'b00}));
        tbl_ent_addr = {tbl_ppn, {OFF_BITS{1'b0}}} + AW'(TBL_OFS_W'({tbl_idx, 2'b00}));
        paddr        = {page_ppn, pg_off};
    end

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  acc_e              acc,
    output logic              present,
    output logic              allowed,
    output logic              needs_dirty
);

    always_comb begin
        present = flags[F_VALID];
        unique case (acc)
            ACC_READ:  allowed = flags[F_RD];
            ACC_WRITE: allowed = flags[F_WR];
            ACC_EXEC:  allowed = flags[F_EX];
            default:   allowed = 1'b0;
        endcase
        needs_dirty = (acc == ACC_WRITE) && !flags[F_DIRTY];
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned DIR_BITS = 10,
    parameter int unsigned TBL_BITS = 10,
    parameter int unsigned OFF_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_vaddr,
    input  logic [1:0]    req_acc,
    input  logic [AW-1:0] base_reg,
    output logic          busy,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_cause,
    output logic [AW-1:0] rsp_vaddr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata
);

    localparam int unsigned PPN_W = AW - OFF_BITS;

    walk_state_e state_q, state_d;

    logic [AW-1:0]    vaddr_q;
    logic [AW-1:0]    base_q;
    acc_e             acc_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [AW-1:0]    pte_q;
    logic [AW-1:0]    paddr_q;
    cause_e           cause_q;

    logic [AW-1:0] dir_ent_addr;
    logic [AW-1:0] tbl_ent_addr;
    logic [AW-1:0] paddr_new;
    logic          ent_present;
    logic          ent_allowed;
    logic          ent_needs_dirty;
    logic          accept;

    ptw_addr_gen #(
        .AW       (AW),
        .DIR_BITS (DIR_BITS),
        .TBL_BITS (TBL_BITS),
        .OFF_BITS (OFF_BITS)
    ) u_addr (
        .vaddr        (vaddr_q),
        .base         (base_q),
        .tbl_ppn      (tbl_ppn_q),
        .page_ppn     (mem_rdata[AW-1:OFF_BITS]),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .paddr        (paddr_new)
    );

    ptw_perm_check u_perm (
        .flags       (mem_rdata[FLAG_W-1:0]),
        .acc         (acc_q),
        .present     (ent_present),
        .allowed     (ent_allowed),
        .needs_dirty (ent_needs_dirty)
    );

    assign accept = (state_q == S_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_DIR_RD;
            S_DIR_RD:   if (mem_ack)   state_d = ent_present ? S_TBL_RD : S_DONE;
            S_TBL_RD: begin
                if (mem_ack) begin
                    if (ent_present && ent_allowed && ent_needs_dirty)
                        state_d = S_DIRTY_WR;
                    else
                        state_d = S_DONE;
                end
            end
            S_DIRTY_WR: if (mem_ack)   state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // walk datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q   <= '0;
            base_q    <= '0;
            acc_q     <= ACC_READ;
            tbl_ppn_q <= '0;
            pte_q     <= '0;
            paddr_q   <= '0;
            cause_q   <= CAUSE_OK;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                base_q  <= base_reg;
                acc_q   <= acc_e'(req_acc);
                paddr_q <= '0;
                cause_q <= CAUSE_OK;
            end
            if (state_q == S_DIR_RD && mem_ack) begin
                if (ent_present) tbl_ppn_q <= mem_rdata[AW-1:OFF_BITS];
                else             cause_q   <= CAUSE_NP;
            end
            if (state_q == S_TBL_RD && mem_ack) begin
                pte_q <= mem_rdata;
                if (!ent_present) begin
                    cause_q <= CAUSE_NP;
                end else if (!ent_allowed) begin
                    cause_q <= CAUSE_PROT;
                end else begin
                    cause_q <= CAUSE_OK;
                    paddr_q <= paddr_new;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        rsp_valid = (state_q == S_DONE);
        rsp_paddr = paddr_q;
        rsp_cause = cause_q;
        rsp_vaddr = vaddr_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_ent_addr;
            end
            S_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_ent_addr;
            end
            S_DIRTY_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_ent_addr;
                mem_wdata = pte_q | (AW'(1) << F_DIRTY);
            end
            default: ;
        endcase
    end

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != CAUSE_OK) |-> (rsp_paddr == '0));

    // R6
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (acc_q == ACC_WRITE));

endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] base_reg = '0;
    logic        busy, rsp_valid, mem_req, mem_we;
    logic [31:0] rsp_paddr, rsp_vaddr, mem_addr, mem_wdata;
    logic [1:0]  rsp_cause;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .base_reg(base_reg), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause), .rsp_vaddr(rsp_vaddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // sparse memory model with access log
    logic [31:0] mem [logic [31:0]];
    int          lat = 0;
    int          acc_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] log_addr [0:7];

    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                repeat (lat) @(negedge clk);
                if (acc_cnt < 8) log_addr[acc_cnt] = mem_addr;
                acc_cnt++;
                if (mem_we) begin
                    wr_cnt++;
                    mem[mem_addr] = mem_wdata;
                    mem_rdata = '0;
                end else begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    function automatic logic [31:0] dir_addr(input logic [31:0] b, input logic [31:0] va);
        return b + {20'h0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] tbl_addr(input logic [19:0] tpage, input logic [31:0] va);
        return {tpage, 12'h000} + {20'h0, va[21:12], 2'b00};
    endfunction

    task automatic map(input logic [31:0] b, input logic [31:0] va, input logic [19:0] tpage, input logic [31:0] pte);
        mem[dir_addr(b, va)] = {tpage, 12'h001};
        mem[tbl_addr(tpage, va)] = pte;
    endtask

    // scoreboard
    typedef struct {
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  cause;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int   rsp_cnt = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                rsp_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected response", rsp_vaddr, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_cause == e.cause, {e.tag, " cause"}, 32'(rsp_cause), 32'(e.cause));
                    check(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
                    check(rsp_vaddr == e.va, {"R8 vaddr echo ", e.tag}, rsp_vaddr, e.va);
                end
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic [31:0] b, input logic [31:0] pa, input logic [1:0] cause,
                        input int n_acc, input int n_wr, input bit hold);
        exp_t e;
        int start;
        int wr0;
        e.va = va; e.pa = pa; e.cause = cause; e.tag = tag;
        exp_q.push_back(e);
        acc_cnt = 0;
        wr0 = wr_cnt;
        start = rsp_cnt;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; base_reg = b;
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'h1);
        if (hold) begin
            req_vaddr = 32'h00400123; req_acc = 2'b00;
            while (!rsp_valid) @(negedge clk);
        end
        req_valid = 1'b0;
        while (rsp_cnt == start) @(negedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 single-cycle pulse", 32'(rsp_valid), 32'h0);
        if (hold) begin
            repeat (4) @(negedge clk);
            check(rsp_cnt == start + 1, "R7 held request ignored", 32'(rsp_cnt - start), 32'h1);
            check(busy == 1'b0, "R7 idle after hold", 32'(busy), 32'h0);
        end
        check(acc_cnt == n_acc, {tag, " access count (R4/R6)"}, 32'(acc_cnt), 32'(n_acc));
        check(wr_cnt - wr0 == n_wr, {tag, " write count (R5/R6)"}, 32'(wr_cnt - wr0), 32'(n_wr));
        check(log_addr[0] == dir_addr(b, va), "R1 directory read address", log_addr[0], dir_addr(b, va));
    endtask

    localparam logic [31:0] BA = 32'h10005000;
    localparam logic [31:0] BB = 32'h20008000;
    localparam logic [31:0] VA = 32'h7192a44c;

    initial begin
        map(BA, VA, 20'h12345, 32'h14817007);
        map(BA, 32'h7192b000, 20'h12345, 32'h0AAAA003);
        map(BA, 32'h7192c010, 20'h12345, 32'h0BBBB009);
        map(BB, VA, 20'h33333, 32'h5555500F);

        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy reset", 32'(busy), 32'h0);
        check(rsp_valid == 1'b0, "R10 rsp_valid reset", 32'(rsp_valid), 32'h0);
        check(mem_req == 1'b0, "R10 mem_req reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;

        // R3 R2 read translation, example mapping
        lat = 0;
        walk("R3 read ok", VA, 2'b00, BA, 32'h1481744c, 2'b00, 2, 0, 0);
        check(log_addr[1] == tbl_addr(20'h12345, VA), "R2 table read address", log_addr[1], tbl_addr(20'h12345, VA));
        // R6 first store marks the entry
        lat = 2;
        walk("R6 write clean", VA, 2'b01, BA, 32'h1481744c, 2'b00, 3, 1, 0);
        check(log_addr[2] == tbl_addr(20'h12345, VA), "R6 write address", log_addr[2], tbl_addr(20'h12345, VA));
        check(mem[tbl_addr(20'h12345, VA)] == 32'h14817017, "R6 stored word", mem[tbl_addr(20'h12345, VA)], 32'h14817017);
        // R6 second store: already marked
        lat = 1;
        walk("R6 write dirty", VA, 2'b01, BA, 32'h1481744c, 2'b00, 2, 0, 0);
        // R4 absent directory entry
        lat = 3;
        walk("R4 dir absent", 32'h00400123, 2'b00, BA, 32'h0, 2'b01, 1, 0, 0);
        // R4 absent table entry
        lat = 0;
        walk("R4 table absent", 32'h71800008, 2'b00, BA, 32'h0, 2'b01, 2, 0, 0);
        // R5 execute without permission
        lat = 1;
        walk("R5 exec denied", VA, 2'b10, BA, 32'h0, 2'b10, 2, 0, 0);
        // R5 store to read-only clean page: fault wins, no write
        lat = 2;
        walk("R5 store read-only clean", 32'h7192b000, 2'b01, BA, 32'h0, 2'b10, 2, 0, 0);
        check(mem[tbl_addr(20'h12345, 32'h7192b000)] == 32'h0AAAA003, "R5 entry untouched",
              mem[tbl_addr(20'h12345, 32'h7192b000)], 32'h0AAAA003);
        // R3 execute-only page
        lat = 0;
        walk("R3 exec ok", 32'h7192c010, 2'b10, BA, 32'h0BBBB010, 2'b00, 2, 0, 0);
        walk("R5 read denied", 32'h7192c010, 2'b00, BA, 32'h0, 2'b10, 2, 0, 0);
        // R5 reserved access code
        walk("R5 code 11", VA, 2'b11, BA, 32'h0, 2'b10, 2, 0, 0);
        // R1 another base register
        lat = 3;
        walk("R1 other base", VA, 2'b00, BB, 32'h5555544c, 2'b00, 2, 0, 0);
        // R7 request held across the walk
        lat = 1;
        walk("R7 held request", VA, 2'b00, BB, 32'h5555544c, 2'b00, 2, 0, 1);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule